// File: doc/BRIEF.md
# Key-Guarded Clock Control Register

This block holds the clock-source control byte of a chip and protects it against stray writes. Software reaches it over a simple register bus (address, write strobe, write data, combinational read data). The control byte carries the source select, the enables for each clock source, a flash low-power enable and an enable for primary-oscillator failure detection. Since a bad value here can stop the chip, the control byte changes only after software has written two key bytes to its address in the right order. The first write after that is committed, and the register locks again at once.

Other bus traffic may fall between the keys without breaking the sequence: reads, and writes to any other address. A separate divider byte at its own address needs no keys. On reset the block loads its defaults. The internal precision oscillator is selected and enabled. When a configuration input asks for low power during reset, the flash low-power bit is set and the divider is preset to 08h.

Control byte layout:
- bits [1:0]: source select (00 internal precision, 01 external, 10 low-speed)
- bit 2: internal enable
- bit 3: external enable
- bit 4: low-speed enable
- bit 5: flash low-power enable
- bit 6: failure-detect enable
- bit 7: reserved; it reads 0 and writes to it are dropped.

Top module: `clk_guard_reg`

## Requirements
- R1: With lowPwrRstOff high during reset, the block leaves reset with lockState 0 (locked), ctrlValue 04h (internal source selected and enabled) and divValue 00h.
- R2: With lowPwrRstOff low during reset, the block leaves reset with ctrlValue 24h (flash low-power bit 5 set) and divValue 08h.
- R3: A write of KEY_A (E7h) and then a write of KEY_B (18h) to CTRL_ADDR open the lock. lockState reads 1 after the first key and 2 after the second. The next write to CTRL_ADDR loads ctrlValue with the write data with bit 7 cleared, one clock after the write.
- R4: Reads, and writes to addresses other than CTRL_ADDR, leave the unlock progress unchanged when they fall between the keys or between the second key and the data write.
- R5: While one key has been seen, a write of KEY_A to CTRL_ADDR keeps lockState at 1. Any other value except KEY_B returns it to 0. While locked, any value other than KEY_A keeps it at 0.
- R6: Writes to CTRL_ADDR while lockState is 0 or 1 never change ctrlValue.
- R7: Each unlock admits exactly one commit. The write that commits returns lockState to 0, so a following write to CTRL_ADDR leaves ctrlValue unchanged.
- R8: commitPulse is high for exactly the one cycle after a committed write and is low at all other times.
- R9: divValue is loaded from any write to DIV_ADDR, with no keys needed, and this does not depend on the lock state.
- R10: busRdata shows ctrlValue when busAddr equals CTRL_ADDR, divValue when it equals DIV_ADDR, and 00h otherwise. failDetectEn follows bit 6 of ctrlValue.
- R11: A cycle with busWe low never changes lockState.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous reset, active low |
| lowPwrRstOff | input | 1 | Configuration bit; low requests low-power defaults at reset |
| busAddr | input | ADDR_W | Register address |
| busWe | input | 1 | Write strobe |
| busWdata | input | DATA_W | Write data |
| busRdata | output | DATA_W | Read data for busAddr |
| ctrlValue | output | DATA_W | Current control byte |
| divValue | output | DATA_W | Current divider byte |
| failDetectEn | output | 1 | Failure-detect enable (control bit 6) |
| commitPulse | output | 1 | One-cycle pulse after a protected write takes effect |
| lockState | output | 2 | 0 locked, 1 first key seen, 2 open |

## Verification
The bench builds the block with CTRL_ADDR = 3h and DIV_ADDR = Ah instead of the defaults, with the key values left at E7h and 18h. Non-zero, non-adjacent addresses show that the decode truly depends on the parameters and that writes to a third address (5h) are ignored. Those settings let the bench interleave divider writes, foreign writes and reads between the keys. They also let it repeat the first key, break the sequence with a wrong byte, and use the keys as ordinary data.

// File: rtl/clkg_pkg.sv
package clkg_pkg;

  typedef enum logic [1:0] {
    LK_LOCKED = 2'd0,
    LK_KEY1   = 2'd1,
    LK_OPEN   = 2'd2
  } lockSt_t;

  typedef struct packed {
    logic ctrlCommit;
    logic divWrite;
  } regStrobe_t;

endpackage

// File: rtl/clkg_ctrl.sv
module clkg_ctrl
  import clkg_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 8,
  parameter logic [ADDR_W-1:0] CTRL_ADDR = '0,
  parameter logic [ADDR_W-1:0] DIV_ADDR = ADDR_W'(1),
  parameter logic [DATA_W-1:0] KEY_A = DATA_W'(8'hE7),
  parameter logic [DATA_W-1:0] KEY_B = DATA_W'(8'h18)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWe,
  input  logic [DATA_W-1:0] busWdata,
  output regStrobe_t        strobe,
  output lockSt_t           lockState
);

  logic    hitCtrl;
  lockSt_t nextState;

  assign hitCtrl = busWe && (busAddr == CTRL_ADDR);

  always_comb begin
    nextState = lockState;
    if (hitCtrl) begin
      unique case (lockState)
        LK_LOCKED: nextState = (busWdata == KEY_A) ? LK_KEY1 : LK_LOCKED;
        LK_KEY1: begin
          if (busWdata == KEY_B)      nextState = LK_OPEN;
          else if (busWdata == KEY_A) nextState = LK_KEY1;
          else                        nextState = LK_LOCKED;
        end
        LK_OPEN:   nextState = LK_LOCKED;
        default:   nextState = LK_LOCKED;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) lockState <= LK_LOCKED;
    else       lockState <= nextState;
  end

  assign strobe.ctrlCommit = hitCtrl && (lockState == LK_OPEN);
  assign strobe.divWrite   = busWe && (busAddr == DIV_ADDR);

endmodule

// File: rtl/clkg_data.sv
module clkg_data
  import clkg_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 8,
  parameter logic [ADDR_W-1:0] CTRL_ADDR = '0,
  parameter logic [ADDR_W-1:0] DIV_ADDR = ADDR_W'(1),
  parameter logic [DATA_W-1:0] DIV_LP_PRESET = DATA_W'(8'h08)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              lowPwrRstOff,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWdata,
  input  regStrobe_t        strobe,
  output logic [DATA_W-1:0] busRdata,
  output logic [DATA_W-1:0] ctrlValue,
  output logic [DATA_W-1:0] divValue,
  output logic              failDetectEn,
  output logic              commitPulse
);

  // Control byte field positions
  localparam int INT_EN_BIT   = 2;
  localparam int FLASH_LP_BIT = 5;
  localparam int FAIL_DET_BIT = 6;
  localparam int RSVD_BIT     = 7;

  localparam logic [DATA_W-1:0] CTRL_BASE  = DATA_W'(1) << INT_EN_BIT;
  localparam logic [DATA_W-1:0] CTRL_LP    = CTRL_BASE | (DATA_W'(1) << FLASH_LP_BIT);
  localparam logic [DATA_W-1:0] WRITE_MASK = ~(DATA_W'(1) << RSVD_BIT);

  logic lpActive;
  assign lpActive = !lowPwrRstOff;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ctrlValue   <= lpActive ? CTRL_LP : CTRL_BASE;
      divValue    <= lpActive ? DIV_LP_PRESET : '0;
      commitPulse <= 1'b0;
    end else begin
      if (strobe.ctrlCommit) ctrlValue <= busWdata & WRITE_MASK;
      if (strobe.divWrite)   divValue  <= busWdata;
      commitPulse <= strobe.ctrlCommit;
    end
  end

  always_comb begin
    if (busAddr == CTRL_ADDR)     busRdata = ctrlValue;
    else if (busAddr == DIV_ADDR) busRdata = divValue;
    else                          busRdata = '0;
  end

  assign failDetectEn = ctrlValue[FAIL_DET_BIT];

endmodule

// File: rtl/clk_guard_reg.sv
module clk_guard_reg
  import clkg_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 8,
  parameter logic [ADDR_W-1:0] CTRL_ADDR = '0,
  parameter logic [ADDR_W-1:0] DIV_ADDR = ADDR_W'(1),
  parameter logic [DATA_W-1:0] KEY_A = DATA_W'(8'hE7),
  parameter logic [DATA_W-1:0] KEY_B = DATA_W'(8'h18),
  parameter logic [DATA_W-1:0] DIV_LP_PRESET = DATA_W'(8'h08)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              lowPwrRstOff,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWe,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  output logic [DATA_W-1:0] ctrlValue,
  output logic [DATA_W-1:0] divValue,
  output logic              failDetectEn,
  output logic              commitPulse,
  output logic [1:0]        lockState
);

  regStrobe_t strobe;
  lockSt_t    lockSt;

  clkg_ctrl #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CTRL_ADDR(CTRL_ADDR),
    .DIV_ADDR(DIV_ADDR), .KEY_A(KEY_A), .KEY_B(KEY_B)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWe(busWe),
    .busWdata(busWdata), .strobe(strobe), .lockState(lockSt)
  );

  clkg_data #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CTRL_ADDR(CTRL_ADDR),
    .DIV_ADDR(DIV_ADDR), .DIV_LP_PRESET(DIV_LP_PRESET)
  ) u_data (
    .clk(clk), .rstN(rstN), .lowPwrRstOff(lowPwrRstOff), .busAddr(busAddr),
    .busWdata(busWdata), .strobe(strobe), .busRdata(busRdata),
    .ctrlValue(ctrlValue), .divValue(divValue), .failDetectEn(failDetectEn),
    .commitPulse(commitPulse)
  );

  assign lockState = lockSt;

endmodule

// File: rtl/clk_guard_reg_chk.sv
module clk_guard_reg_chk #(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 8,
  parameter logic [ADDR_W-1:0] CTRL_ADDR = '0
) (
  input logic              clk,
  input logic              rstN,
  input logic [ADDR_W-1:0] busAddr,
  input logic              busWe,
  input logic [DATA_W-1:0] ctrlValue,
  input logic              commitPulse,
  input logic [1:0]        lockState
);

  // R3: a commit only follows a control-address write made while open
  a_r3_commit_from_open: assert property (@(posedge clk) disable iff (!rstN)
    commitPulse |-> ($past(lockState) == 2'd2 && $past(busWe) && $past(busAddr) == CTRL_ADDR));

  // R5: the lock can never jump straight from locked to open
  a_r5_no_skip: assert property (@(posedge clk) disable iff (!rstN)
    (lockState == 2'd0) |=> (lockState != 2'd2));

  // R4: writes elsewhere leave the unlock progress alone
  a_r4_other_addr_holds: assert property (@(posedge clk) disable iff (!rstN)
    (busWe && busAddr != CTRL_ADDR) |=> $stable(lockState));

  // R11: reads never move the lock
  a_r11_read_holds_state: assert property (@(posedge clk) disable iff (!rstN)
    (!busWe) |=> $stable(lockState));

  // R6: the control byte moves only together with a commit pulse
  a_r6_ctrl_stable: assert property (@(posedge clk) disable iff (!rstN)
    (!commitPulse) |-> $stable(ctrlValue));

  // R7: a commit leaves the register locked
  a_r7_relock: assert property (@(posedge clk) disable iff (!rstN)
    commitPulse |-> (lockState == 2'd0));

  // R8: the pulse never lasts two cycles (a commit needs two keys first)
  a_r8_single_pulse: assert property (@(posedge clk) disable iff (!rstN)
    commitPulse |=> !commitPulse);

  // R1: the state encoding never leaves its three values
  a_r1_state_legal: assert property (@(posedge clk) disable iff (!rstN)
    lockState != 2'd3);

endmodule

bind clk_guard_reg clk_guard_reg_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CTRL_ADDR(CTRL_ADDR)
) u_chk (
  .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWe(busWe),
  .ctrlValue(ctrlValue), .commitPulse(commitPulse), .lockState(lockState)
);

// File: tb/clk_guard_reg_bench.sv
module clk_guard_reg_bench;

  localparam logic [3:0] CA = 4'h3;
  localparam logic [3:0] DA = 4'hA;
  localparam logic [3:0] XA = 4'h5;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       lowPwrRstOff = 1'b1;
  logic [3:0] busAddr = '0;
  logic       busWe = 1'b0;
  logic [7:0] busWdata = '0;
  logic [7:0] busRdata, ctrlValue, divValue;
  logic       failDetectEn, commitPulse;
  logic [1:0] lockState;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  typedef struct {
    string      tag;
    logic [7:0] ctrl;
    logic [7:0] div;
    logic [1:0] lock;
    logic       commit;
  } item_t;

  item_t sbQ[$];

  // bench-side model of the expected register state
  logic [7:0] mCtrl, mDiv;
  logic [1:0] mLock;

  always #10 clk = ~clk;

  clk_guard_reg #(.CTRL_ADDR(CA), .DIV_ADDR(DA)) u_clk_guard_reg (
    .clk(clk), .rstN(rstN), .lowPwrRstOff(lowPwrRstOff), .busAddr(busAddr),
    .busWe(busWe), .busWdata(busWdata), .busRdata(busRdata),
    .ctrlValue(ctrlValue), .divValue(divValue), .failDetectEn(failDetectEn),
    .commitPulse(commitPulse), .lockState(lockState)
  );

  task automatic pushItem(input string tag, input logic commit);
    item_t it;
    it.tag = tag; it.ctrl = mCtrl; it.div = mDiv; it.lock = mLock; it.commit = commit;
    sbQ.push_back(it);
  endtask

  task automatic busWrite(input logic [3:0] a, input logic [7:0] d, input string tag);
    logic commit;
    commit = 1'b0;
    @(negedge clk);
    busAddr = a; busWdata = d; busWe = 1'b1;
    @(posedge clk);
    #1;
    busWe = 1'b0;
    if (a == CA) begin
      case (mLock)
        2'd0: mLock = (d == 8'hE7) ? 2'd1 : 2'd0;
        2'd1: mLock = (d == 8'h18) ? 2'd2 : ((d == 8'hE7) ? 2'd1 : 2'd0);
        default: begin mCtrl = d & 8'h7F; commit = 1'b1; mLock = 2'd0; end
      endcase
    end
    if (a == DA) mDiv = d;
    pushItem(tag, commit);
  endtask

  task automatic idleCycle(input string tag);
    @(negedge clk);
    busWe = 1'b0;
    @(posedge clk);
    #1;
    pushItem(tag, 1'b0);
  endtask

  task automatic busRead(input logic [3:0] a, input logic [7:0] exp, input string tag);
    @(negedge clk);
    busWe = 1'b0; busAddr = a;
    #2;
    checks++;
    if (busRdata !== exp) begin
      errors++;
      $display("FAIL %s: rdata actual %02h expected %02h", tag, busRdata, exp);
    end
    @(posedge clk);
    #1;
    pushItem({tag, " state"}, 1'b0);
  endtask

  task automatic doReset(input logic cfgOff);
    @(negedge clk);
    rstN = 1'b0; lowPwrRstOff = cfgOff; busWe = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    mLock = 2'd0;
    mCtrl = cfgOff ? 8'h04 : 8'h24;
    mDiv  = cfgOff ? 8'h00 : 8'h08;
  endtask

  // monitor: compare one expected item per cycle, away from the edge
  initial begin
    forever begin
      @(negedge clk);
      if (sbQ.size() > 0) begin
        item_t it;
        it = sbQ.pop_front();
        checks++;
        if (ctrlValue !== it.ctrl || divValue !== it.div || lockState !== it.lock ||
            commitPulse !== it.commit || failDetectEn !== it.ctrl[6]) begin
          errors++;
          $display("FAIL %s: actual ctrl=%02h div=%02h lock=%0d commit=%0b fd=%0b expected ctrl=%02h div=%02h lock=%0d commit=%0b fd=%0b",
                   it.tag, ctrlValue, divValue, lockState, commitPulse, failDetectEn,
                   it.ctrl, it.div, it.lock, it.commit, it.ctrl[6]);
        end
      end
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    doReset(1'b1);
    idleCycle("R1 reset defaults");
    busRead(CA, 8'h04, "R10 read ctrl");
    busRead(DA, 8'h00, "R10 read div");
    busRead(XA, 8'h00, "R10 read unmapped");

    busWrite(CA, 8'h55, "R6 locked write ignored");
    busWrite(CA, 8'hE7, "R3 first key");
    busWrite(DA, 8'h3C, "R9 div write between keys");
    busRead(CA, 8'h04, "R11 read between keys");
    busWrite(XA, 8'h99, "R4 foreign write between keys");
    busWrite(CA, 8'h18, "R3 second key");
    busWrite(DA, 8'h11, "R4 div write while open");
    busRead(DA, 8'h11, "R9 div readback");
    busWrite(CA, 8'h4B, "R3 R8 commit");
    idleCycle("R8 pulse ends");
    busRead(CA, 8'h4B, "R10 read committed ctrl");
    busWrite(CA, 8'h00, "R7 second write after commit ignored");

    busWrite(CA, 8'hE7, "R5 key1");
    busWrite(CA, 8'hE7, "R5 repeated key1 holds");
    busWrite(CA, 8'h18, "R5 key2 after repeat");
    busWrite(CA, 8'hFF, "R3 commit masks bit7");

    busWrite(CA, 8'hE7, "R5 key1 again");
    busWrite(CA, 8'h20, "R5 wrong byte relocks");
    busWrite(CA, 8'h18, "R5 lone key2 stays locked");
    busWrite(CA, 8'h01, "R6 write after broken sequence ignored");

    busWrite(CA, 8'h18, "R5 key2 first stays locked");
    busWrite(CA, 8'hE7, "R3 key1 third time");
    busWrite(CA, 8'h42, "R6 non-key in key1 ignored");
    busWrite(CA, 8'hE7, "R3 key1 fourth time");
    busWrite(CA, 8'h18, "R3 key2 fourth time");
    busWrite(CA, 8'hE7, "R3 key value as data commits");
    idleCycle("R8 idle after key-data commit");

    doReset(1'b0);
    idleCycle("R2 low-power reset defaults");
    busRead(DA, 8'h08, "R2 read div preset");
    busWrite(DA, 8'hA5, "R9 div write while locked");
    idleCycle("R9 settle");

    repeat (3) @(posedge clk);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule